// File: doc/BRIEF.md
# HD Video Line CRC Checker

This block checks the per-line error-detection code that a high-definition serial-video stream carries for each of its two channels. It sits after word alignment and timing decoding. It receives a 20-bit word stream in which bits [19:10] carry luma and bits [9:0] carry chroma. It also receives a valid strobe and two markers from the timing decoder. One marker flags the last word of the start-of-active-video sequence. The other marker flags the two CRC words.

For each channel the block recomputes an 18-bit CRC over the covered words of a line. After the second CRC word it compares the result with the received code. It then raises a one-cycle done pulse and updates a luma flag and a chroma flag independently. Each flag keeps its value until the next comparison. The per-channel calculator is a separate module: it clears, accumulates and presents the running code, so a transmitter can instantiate it to produce the code words it inserts.

Top module: `hd_line_crc_check`

## Requirements
- R1: While reset is high and in the first cycle after it falls, err_y_o, err_c_o and done_o are all 0.
- R2: Each channel's code starts at zero at a start marker. Each covered 10-bit channel word is folded in least significant bit first. For each bit d, let fb = d xor c[0]; the register shifts right by one, and when fb is 1, bits 17, 13 and 12 are inverted. This is generator x^18 + x^5 + x^4 + 1 in reflected form. Luma uses word bits [19:10] and chroma uses bits [9:0].
- R3: Coverage starts with the first valid word after the start-marked word. It includes every valid word up to, but not including, the first CRC-marked word. That range covers the end-of-active-video sequence and both line-number words. Words before a start marker do not affect the result.
- R4: Within each channel field, the first CRC word carries code bits [8:0] in field bits [8:0], and the second carries code bits [17:9] in field bits [8:0]. Field bit 9 has no effect on the result.
- R5: done_o is high for exactly one cycle, in the cycle after the second CRC word, and both flags take their new values in that same cycle.
- R6: Each flag is 1 exactly when its own channel's received code differs from its recomputed code. A mismatch in one channel leaves the other channel's flag at 0.
- R7: Between comparisons, both flags hold their last values, including across the words of later lines.
- R8: A cycle with valid_i low changes nothing, whatever the word and marker inputs are.
- R9: A start marker during coverage restarts the line from zero. CRC-marked words that arrive when no line is being covered produce no done pulse and no flag change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| word_i | input | 20 | Aligned word; [19:10] luma, [9:0] chroma |
| valid_i | input | 1 | Word strobe |
| sav_i | input | 1 | Marks the last word of the start-of-active-video sequence |
| crc_i | input | 1 | Marks each of the two CRC words |
| err_y_o | output | 1 | Sticky luma mismatch flag |
| err_c_o | output | 1 | Sticky chroma mismatch flag |
| done_o | output | 1 | One-cycle comparison pulse |

## Verification
A wrong running code, a missed clear or a coverage window that is one word off stays invisible until the line ends. It then shows as a wrongly raised or wrongly cleared flag in the cycle of the done pulse, and only for the channel that is affected. A wrong line-state value appears sooner: a done pulse goes missing or arrives at a CRC word outside a line, in the cycle after that word. The bench keeps its own model of the code and the line state, and compares all three outputs on every clock. Because of this, an error is reported at the first done pulse that follows it.

// File: rtl/hd_crc_pkg.sv
package hd_crc_pkg;
  localparam int HD_CRC_W = 18;
  localparam int HD_CH_W  = 10;
  localparam logic [HD_CRC_W-1:0] HD_POLY = 18'h00031;

  typedef enum logic [1:0] {
    LS_IDLE  = 2'd0,
    LS_COVER = 2'd1,
    LS_GOTLO = 2'd2
  } line_state_e;
endpackage

// File: rtl/hd_crc_core.sv
module hd_crc_core #(
  parameter int CRC_W  = 18,
  parameter int DATA_W = 10,
  parameter logic [CRC_W-1:0] POLY = 'h31
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_i,
  input  logic              en_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [CRC_W-1:0]  crc_o
);
  function automatic logic [CRC_W-1:0] rev_bits(input logic [CRC_W-1:0] v);
    logic [CRC_W-1:0] r;
    for (int i = 0; i < CRC_W; i++) r[i] = v[CRC_W-1-i];
    return r;
  endfunction

  localparam logic [CRC_W-1:0] RPOLY = rev_bits(POLY);

  logic [CRC_W-1:0] crc_q, crc_nxt;

  always_comb begin
    logic fb;
    crc_nxt = crc_q;
    for (int i = 0; i < DATA_W; i++) begin
      fb      = crc_nxt[0] ^ data_i[i];
      crc_nxt = (crc_nxt >> 1) ^ (fb ? RPOLY : '0);
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr_i) crc_q <= '0;
    else if (en_i)    crc_q <= crc_nxt;
  end

  assign crc_o = crc_q;

  // R2
  clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (crc_o == '0));

  // R8
  accumulate_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !(clr_i || en_i) |=> $stable(crc_o));
endmodule

// File: rtl/hd_crc_chan.sv
module hd_crc_chan #(
  parameter int CRC_W  = 18,
  parameter int DATA_W = 10,
  parameter logic [CRC_W-1:0] POLY = 'h31
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_i,
  input  logic              acc_i,
  input  logic              cap_lo_i,
  input  logic              cmp_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              err_o
);
  localparam int HALF_W = CRC_W / 2;

  logic [CRC_W-1:0]  crc;
  logic [HALF_W-1:0] lo_q;
  logic              err_q;

  hd_crc_core #(.CRC_W(CRC_W), .DATA_W(DATA_W), .POLY(POLY)) u_core (
    .clk    (clk),
    .rst    (rst),
    .clr_i  (clr_i),
    .en_i   (acc_i),
    .data_i (data_i),
    .crc_o  (crc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q  <= '0;
      err_q <= 1'b0;
    end else begin
      if (cap_lo_i) lo_q  <= data_i[HALF_W-1:0];
      if (cmp_i)    err_q <= ({data_i[HALF_W-1:0], lo_q} != crc);
    end
  end

  assign err_o = err_q;

  // R7
  err_only_on_cmp_chk: assert property (@(posedge clk) disable iff (rst)
    !cmp_i |=> $stable(err_o));
endmodule

// File: rtl/hd_line_crc_check.sv
module hd_line_crc_check
  import hd_crc_pkg::*;
#(
  parameter int CRC_W = HD_CRC_W,
  parameter int CH_W  = HD_CH_W,
  parameter logic [CRC_W-1:0] POLY = HD_POLY
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [2*CH_W-1:0]    word_i,
  input  logic                 valid_i,
  input  logic                 sav_i,
  input  logic                 crc_i,
  output logic                 err_y_o,
  output logic                 err_c_o,
  output logic                 done_o
);
  localparam int NCH = 2;

  line_state_e st_q;
  logic        done_q;
  logic        clr, acc, cap_lo, cmp;
  logic [NCH-1:0] err;

  always_comb begin
    clr    = valid_i && sav_i;
    acc    = valid_i && !sav_i && !crc_i && (st_q == LS_COVER);
    cap_lo = valid_i && !sav_i &&  crc_i && (st_q == LS_COVER);
    cmp    = valid_i && !sav_i &&  crc_i && (st_q == LS_GOTLO);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= LS_IDLE;
      done_q <= 1'b0;
    end else begin
      done_q <= cmp;
      if (clr)         st_q <= LS_COVER;
      else if (cap_lo) st_q <= LS_GOTLO;
      else if (cmp)    st_q <= LS_IDLE;
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    hd_crc_chan #(.CRC_W(CRC_W), .DATA_W(CH_W), .POLY(POLY)) u_chan (
      .clk      (clk),
      .rst      (rst),
      .clr_i    (clr),
      .acc_i    (acc),
      .cap_lo_i (cap_lo),
      .cmp_i    (cmp),
      .data_i   (word_i[g*CH_W +: CH_W]),
      .err_o    (err[g])
    );
  end

  assign err_c_o = err[0];
  assign err_y_o = err[1];
  assign done_o  = done_q;

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R5
  done_cause_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> $past(valid_i && crc_i && !sav_i));

  // R7
  flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> ($stable(err_y_o) && $stable(err_c_o)));

  // R9
  no_done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == LS_IDLE) |=> !done_o);
endmodule

// File: tb/hd_line_crc_check_bench.sv
module hd_line_crc_check_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [19:0] word_i = '0;
  logic valid_i = 1'b0, sav_i = 1'b0, crc_i = 1'b0;
  logic err_y_o, err_c_o, done_o;

  int checks = 0, errors = 0;
  bit finished = 0;

  // reference model state
  bit act = 0, gotlo = 0;
  int unsigned my = 0, mc = 0, ly = 0, lc = 0;
  bit ey = 0, ec = 0, ed = 0;

  always #10 clk = ~clk;

  hd_line_crc_check u_hd_line_crc_check (
    .clk(clk), .rst(rst), .word_i(word_i), .valid_i(valid_i),
    .sav_i(sav_i), .crc_i(crc_i), .err_y_o(err_y_o), .err_c_o(err_c_o),
    .done_o(done_o)
  );

  function automatic int unsigned ref_crc(int unsigned c, int unsigned d);
    for (int b = 0; b < 10; b++) begin
      int unsigned fb;
      fb = (c ^ (d >> b)) & 1;
      c = c >> 1;
      if (fb != 0) c = c ^ ((1 << 17) | (1 << 13) | (1 << 12));
    end
    return c & 32'h3ffff;
  endfunction

  task automatic check(string tag);
    checks++;
    if (err_y_o !== ey || err_c_o !== ec || done_o !== ed) begin
      errors++;
      $display("FAIL %s: actual y=%b c=%b done=%b expected y=%b c=%b done=%b",
               tag, err_y_o, err_c_o, done_o, ey, ec, ed);
    end
  endtask

  task automatic model(logic [19:0] w, bit v, bit s, bit c);
    ed = 0;
    if (!v) return;
    if (s) begin
      act = 1; gotlo = 0; my = 0; mc = 0;
    end else if (act && !c) begin
      my = ref_crc(my, w[19:10]);
      mc = ref_crc(mc, w[9:0]);
    end else if (act && c && !gotlo) begin
      ly = w[18:10]; lc = w[8:0]; gotlo = 1;
    end else if (act && c) begin
      ey = ((int'(w[18:10]) << 9) | ly) != my;
      ec = ((int'(w[8:0]) << 9) | lc) != mc;
      ed = 1; act = 0; gotlo = 0;
    end
  endtask

  task automatic step(logic [19:0] w, bit v, bit s, bit c, string tag);
    @(negedge clk);
    check(tag);
    word_i = w; valid_i = v; sav_i = s; crc_i = c;
    model(w, v, s, c);
  endtask

  // gen_y/gen_c track the code the bench itself expects for the words it sends
  task automatic send_line(int n, int unsigned mask_y, int unsigned mask_c,
                           bit flip9, bit gaps, string tag);
    int unsigned gy = 0, gc = 0, ty, tc;
    logic [19:0] w;
    step(20'h00000, 1, 1, 0, tag);
    for (int i = 0; i < n + 6; i++) begin
      if (gaps && (i % 3 == 1))
        step(20'($urandom), 0, 1'($urandom), 1'($urandom), tag);
      w = 20'($urandom);
      gy = ref_crc(gy, w[19:10]);
      gc = ref_crc(gc, w[9:0]);
      step(w, 1, 0, 0, tag);
    end
    ty = gy ^ mask_y; tc = gc ^ mask_c;
    for (int h = 0; h < 2; h++) begin
      int unsigned py, pc;
      py = (ty >> (9 * h)) & 9'h1ff;
      pc = (tc >> (9 * h)) & 9'h1ff;
      w = {~py[8] ^ flip9, py[8:0], ~pc[8] ^ flip9, pc[8:0]};
      if (gaps) step(20'($urandom), 0, 1'($urandom), 1, tag);
      step(w, 1, 0, 1, tag);
    end
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) step(20'($urandom), 0, 0, 0, tag);
  endtask

  initial begin
    repeat (3) begin
      @(negedge clk);
      checks++;
      if (err_y_o !== 0 || err_c_o !== 0 || done_o !== 0) begin
        errors++;
        $display("FAIL R1: actual y=%b c=%b done=%b expected 0 0 0",
                 err_y_o, err_c_o, done_o);
      end
    end
    rst = 1'b0;
    idle(3, "R1");
    // garbage before any start marker, including stray CRC words
    step(20'h3ff00, 1, 0, 0, "R9");
    step(20'h12345, 1, 0, 1, "R9");
    step(20'h54321, 1, 0, 1, "R9");
    idle(2, "R9");
    send_line(12, 0, 0, 0, 0, "R2");
    idle(2, "R5");
    send_line(20, 1, 0, 0, 0, "R6");
    idle(4, "R6");
    send_line(8, 0, 32'h20000, 0, 0, "R4");
    idle(2, "R7");
    // flags held across words of the next line until its comparison
    send_line(30, 0, 0, 0, 0, "R7");
    send_line(10, 32'h00100, 32'h00200, 0, 0, "R4");
    send_line(10, 0, 0, 1, 0, "R4");
    send_line(16, 32'h3, 0, 0, 1, "R8");
    send_line(16, 0, 0, 0, 1, "R8");
    // start marker mid-line restarts coverage
    step(20'h00000, 1, 1, 0, "R9");
    for (int i = 0; i < 5; i++) step(20'($urandom), 1, 0, 0, "R9");
    send_line(9, 0, 0, 0, 0, "R9");
    // stray CRC words after a finished line
    step(20'h0abcd, 1, 0, 1, "R9");
    step(20'h0dcba, 1, 0, 1, "R9");
    send_line(4, 0, 1, 0, 0, "R3");
    send_line(0, 0, 0, 0, 0, "R3");
    idle(3, "R3");
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule